// File: doc/BRIEF.md
# Registered Parity Generator with Serial Load

This block forms the parity of a 12-bit data word and presents it both as a combinational result and through a single-bit storage register. The combinational result is high only for an odd count of set data bits. A blocking input forces that result low. Both the combinational result and the stored bit come out as true and inverted pairs.

The storage register takes its next value through a two-level selector. The first level either recirculates the stored bit or takes the fresh parity. The second level overrides both with a serial bit from outside. The register is written on a rising edge of either of two strobe inputs. The strobes are sampled by one system clock, so a rising edge on one strobe or on both in the same system cycle writes the register exactly once. An asynchronous reset clears the stored bit.

The selector is built as a small decision over three named sources: SRC_HOLD, SRC_LOAD and SRC_SHIFT. The source is picked each cycle from the two control inputs. A cycle that carries a strobe edge performs the transition to the value of the picked source. A cycle without a strobe edge keeps the current bit.

Top module: `parity_shift_reg`

## Requirements
- R1: `par_out` is 1 exactly when `par_block` is 0 and an odd number of the bits of `data_in` are 1; otherwise it is 0.
- R2: While `par_block` is 1, `par_out` is 0 for every value of `data_in`.
- R3: `par_out_n` is always the inverse of `par_out`, and `reg_out_n` is always the inverse of `reg_out`, including while `rst` is 1.
- R4: In a cycle with a strobe edge and `shift_en` = 1 (SRC_SHIFT), `reg_out` takes the value of `ser_in` after that clock edge, whatever `load_en` is.
- R5: In a cycle with a strobe edge, `shift_en` = 0 and `load_en` = 1 (SRC_LOAD), `reg_out` takes the value `par_out` had in that cycle. This stores 0 while `par_block` is 1.
- R6: In a cycle with a strobe edge, `shift_en` = 0 and `load_en` = 0 (SRC_HOLD), `reg_out` keeps its value.
- R7: Without a strobe edge, `reg_out` does not change, whatever the control, data and serial inputs are.
- R8: A strobe edge is a 0 in one cycle followed by a 1 in the next on `stb_a` or `stb_b`. Either strobe alone or both together cause one write. A strobe held at 1 causes no further writes.
- R9: `rst` = 1 clears `reg_out` at once, without waiting for a clock. Strobe edges while `rst` is 1 are ignored. `reg_out` stays 0 after release until the next strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Asynchronous reset, active high |
| data_in | input | 12 | Data word whose parity is formed |
| par_block | input | 1 | Forces the parity result low when 1 |
| load_en | input | 1 | 1 selects fresh parity, 0 recirculates the stored bit |
| shift_en | input | 1 | 1 selects the serial bit, overriding load_en |
| ser_in | input | 1 | Serial data bit |
| stb_a | input | 1 | First write strobe |
| stb_b | input | 1 | Second write strobe |
| par_out | output | 1 | Combinational parity |
| par_out_n | output | 1 | Inverse of par_out |
| reg_out | output | 1 | Stored bit |
| reg_out_n | output | 1 | Inverse of reg_out |

## Verification
The parity path is swept over all 4096 data words, once with the block input low and once with it high. The first sweep tells odd counts from even counts at every bit position. The second shows that blocking wins over every data value. The register is walked through every mix of the two control inputs, both serial values and both block states. The data words used have odd and even counts, and writes come from strobe A, strobe B and both together. This separates the three sources and shows that loads store the blocked parity. Further runs hold a strobe high while the serial bit changes and leave the strobes idle while the controls change. A reset is asserted between clock edges in the middle of a sequence, with a strobe edge inside it.

// File: rtl/parity_reg_pkg.sv
package parity_reg_pkg;

    // Source feeding the stored bit on a write
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_LOAD  = 2'd1,
        SRC_SHIFT = 2'd2
    } reg_src_e;

endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] word,
    input  logic             block,
    output logic             par
);
    logic [WIDTH:0] acc;

    assign acc[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_xor
            assign acc[i+1] = acc[i] ^ word[i];
        end
    endgenerate

    assign par = acc[WIDTH] & ~block;
endmodule

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] stb,
    output logic           fire
);
    logic [NUM-1:0] prev_q;
    logic [NUM-1:0] rise;

    genvar k;
    generate
        for (k = 0; k < NUM; k++) begin : g_stb
            always_ff @(posedge clk or posedge rst) begin
                if (rst) prev_q[k] <= 1'b0;
                else     prev_q[k] <= stb[k];
            end
            assign rise[k] = stb[k] & ~prev_q[k];
        end
    endgenerate

    assign fire = |rise;
endmodule

// File: rtl/par_sel_reg.sv
module par_sel_reg
    import parity_reg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic load_en,
    input  logic shift_en,
    input  logic ser_in,
    input  logic par_in,
    output logic q
);
    reg_src_e src;
    logic     q_reg;
    logic     q_next;

    // Source decision: the serial path outranks the load path
    always_comb begin
        if (shift_en)     src = SRC_SHIFT;
        else if (load_en) src = SRC_LOAD;
        else              src = SRC_HOLD;
    end

    // Next value for the selected source
    always_comb begin
        unique case (src)
            SRC_SHIFT: q_next = ser_in;
            SRC_LOAD:  q_next = par_in;
            SRC_HOLD:  q_next = q_reg;
            default:   q_next = q_reg;
        endcase
    end

    // Storage, written only on a strobe edge
    always_ff @(posedge clk or posedge rst) begin
        if (rst)       q_reg <= 1'b0;
        else if (fire) q_reg <= q_next;
    end

    assign q = q_reg;
endmodule

// File: rtl/parity_shift_reg.sv
module parity_shift_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_block,
    input  logic              load_en,
    input  logic              shift_en,
    input  logic              ser_in,
    input  logic              stb_a,
    input  logic              stb_b,
    output logic              par_out,
    output logic              par_out_n,
    output logic              reg_out,
    output logic              reg_out_n
);
    localparam int NUM_STB = 2;

    logic               par_w;
    logic               fire_w;
    logic               q_w;
    logic [NUM_STB-1:0] stb_vec;

    assign stb_vec = {stb_b, stb_a};

    parity_tree #(.WIDTH(DATA_W)) u_tree (
        .word  (data_in),
        .block (par_block),
        .par   (par_w)
    );

    strobe_edge #(.NUM(NUM_STB)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb_vec),
        .fire (fire_w)
    );

    par_sel_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire_w),
        .load_en  (load_en),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .par_in   (par_w),
        .q        (q_w)
    );

    assign par_out   = par_w;
    assign par_out_n = ~par_w;
    assign reg_out   = q_w;
    assign reg_out_n = ~q_w;
endmodule

// File: rtl/parity_reg_chk.sv
module parity_reg_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] data_in,
    input logic              par_block,
    input logic              load_en,
    input logic              shift_en,
    input logic              ser_in,
    input logic              stb_a,
    input logic              stb_b,
    input logic              par_out,
    input logic              par_out_n,
    input logic              reg_out,
    input logic              reg_out_n
);
    logic pa_q, pb_q, edge_seen;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pa_q <= 1'b0;
            pb_q <= 1'b0;
        end else begin
            pa_q <= stb_a;
            pb_q <= stb_b;
        end
    end

    assign edge_seen = (stb_a && !pa_q) || (stb_b && !pb_q);

    // R1
    parity_odd_chk: assert property (@(posedge clk) disable iff (rst)
        !par_block |-> (par_out == (($countones(data_in) % 2) == 1)));

    // R2
    blocked_low_chk: assert property (@(posedge clk) disable iff (rst)
        par_block |-> !par_out);

    // R3
    par_pair_chk: assert property (@(posedge clk) par_out_n != par_out);

    // R3
    reg_pair_chk: assert property (@(posedge clk) reg_out_n != reg_out);

    // R4
    shift_take_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && shift_en) |=> (reg_out == $past(ser_in)));

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && !shift_en && load_en) |=> (reg_out == $past(par_out)));

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && !shift_en && !load_en) |=> $stable(reg_out));

    // R7
    idle_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_seen |=> $stable(reg_out));

    // R9
    reset_clear_chk: assert property (@(posedge clk) rst |-> !reg_out);
endmodule

bind parity_shift_reg parity_reg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .data_in   (data_in),
    .par_block (par_block),
    .load_en   (load_en),
    .shift_en  (shift_en),
    .ser_in    (ser_in),
    .stb_a     (stb_a),
    .stb_b     (stb_b),
    .par_out   (par_out),
    .par_out_n (par_out_n),
    .reg_out   (reg_out),
    .reg_out_n (reg_out_n)
);

// File: tb/parity_shift_reg_bench.sv
`timescale 1ns/1ps
module parity_shift_reg_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] data_in = '0;
    logic         par_block = 1'b0;
    logic         load_en = 1'b0;
    logic         shift_en = 1'b0;
    logic         ser_in = 1'b0;
    logic         stb_a = 1'b0;
    logic         stb_b = 1'b0;
    logic         par_out, par_out_n, reg_out, reg_out_n;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    bit  exp_y  = 0;

    always #2 clk = ~clk;

    parity_shift_reg #(.DATA_W(W)) u_parity_shift_reg (
        .clk(clk), .rst(rst), .data_in(data_in), .par_block(par_block),
        .load_en(load_en), .shift_en(shift_en), .ser_in(ser_in),
        .stb_a(stb_a), .stb_b(stb_b), .par_out(par_out), .par_out_n(par_out_n),
        .reg_out(reg_out), .reg_out_n(reg_out_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit ref_par(input logic [W-1:0] v, input bit blk);
        int ones = 0;
        for (int i = 0; i < W; i++) ones += int'((v >> i) & 1);
        return (ones % 2 == 1) && !blk;
    endfunction

    task automatic check_reg(input string req);
        check(reg_out === exp_y, req, int'(reg_out), int'(exp_y));
        check(reg_out_n === !exp_y, "R3", int'(reg_out_n), int'(!exp_y));
    endtask

    // Drive a one-cycle strobe pattern, then drop it and let the edge memory clear
    task automatic pulse(input bit a, input bit b);
        @(negedge clk); stb_a = a; stb_b = b;
        @(negedge clk); stb_a = 0; stb_b = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4.0 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] pats [3];
        pats[0] = 12'h001; pats[1] = 12'h003; pats[2] = 12'h7FF;

        // Reset state (R9, R3)
        #1;
        check(reg_out === 1'b0, "R9", int'(reg_out), 0);
        check(reg_out_n === 1'b1, "R3", int'(reg_out_n), 1);
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        exp_y = 0;
        check_reg("R9");

        // Exhaustive parity sweep (R1, R2, R3)
        for (int blk = 0; blk < 2; blk++) begin
            for (int v = 0; v < (1 << W); v++) begin
                par_block = blk[0];
                data_in = v[W-1:0];
                #1;
                check(par_out === ref_par(data_in, par_block), blk ? "R2" : "R1",
                      int'(par_out), int'(ref_par(data_in, par_block)));
                check(par_out_n === !par_out, "R3", int'(par_out_n), int'(!par_out));
            end
        end

        // Control walk (R4, R5, R6, R8)
        for (int sh = 0; sh < 2; sh++)
        for (int ld = 0; ld < 2; ld++)
        for (int sv = 0; sv < 2; sv++)
        for (int blk = 0; blk < 2; blk++)
        for (int p = 0; p < 3; p++)
        for (int s = 1; s < 4; s++) begin
            @(negedge clk);
            shift_en = sh[0]; load_en = ld[0]; ser_in = sv[0];
            par_block = blk[0]; data_in = pats[p];
            if (sh != 0)      exp_y = sv[0];
            else if (ld != 0) exp_y = ref_par(pats[p], blk[0]);
            pulse(s[0], s[1]);
            check_reg(sh != 0 ? "R4" : (ld != 0 ? "R5" : "R6"));
            if (s == 3) check_reg("R8");
        end

        // Idle strobes: nothing written (R7)
        @(negedge clk);
        shift_en = 1; ser_in = !exp_y; load_en = 1;
        repeat (4) @(negedge clk);
        check_reg("R7");
        shift_en = 0; data_in = 12'h001; par_block = 0;
        repeat (3) @(negedge clk);
        check_reg("R7");

        // Held strobe writes once (R8)
        shift_en = 1; ser_in = 1; stb_b = 1;
        @(negedge clk);
        exp_y = 1;
        check_reg("R8");
        ser_in = 0;
        repeat (3) @(negedge clk);
        check_reg("R8");
        stb_b = 0;
        @(negedge clk);

        // Reset in mid-sequence (R9)
        ser_in = 1;
        pulse(1, 0);
        exp_y = 1;
        check_reg("R4");
        #1 rst = 1;
        #0.5;
        exp_y = 0;
        check_reg("R9");
        @(negedge clk); stb_a = 1;
        @(negedge clk); stb_a = 0;
        @(negedge clk);
        check_reg("R9");
        rst = 0;
        repeat (3) @(negedge clk);
        check_reg("R9");
        pulse(0, 1);
        exp_y = 1;
        check_reg("R9");

        finish_run();
    end
endmodule